// File: doc/BRIEF.md
# Overpower Hiccup Timer

This block protects a power stage against sustained overload. It watches an output-power estimate, given in percent of rated power and refreshed by a valid strobe, and compares it against a trip level with hysteresis. While the estimate is judged to be over the limit, a qualification timer counts 1 ms timebase ticks. If the overload is held for the full qualification window, the block raises a gate-inhibit output for a long fixed off interval. It then releases the gate so that switching can retry. If the overload is still present, the cycle repeats.

The qualification timer is cleared whenever the hysteresis comparator drops out. A short overload therefore never inhibits the gate. During the off interval, the qualification timer is held at zero, so every retry must qualify again over a full window. A saturating counter reports how many shutdowns have occurred since reset. A two-flop synchronizer asserts the reset asynchronously and releases it on the clock.

Top module: `ovp_hiccup_timer`

## Requirements
- R1: When reset is asserted, `gate_inhibit`, `over_flag` and `hiccup_count` all go to zero immediately, even in the middle of an off interval.
- R2: A valid estimate (`est_vld`=1) with `est_pct` of 127 or more sets `over_flag` at the next clock edge.
- R3: A valid estimate below 122 clears `over_flag`. A valid estimate from 122 to 126 leaves `over_flag` unchanged.
- R4: An estimate presented with `est_vld`=0 has no effect on `over_flag`.
- R5: Counting only ticks taken while `over_flag` is high, `gate_inhibit` rises on the clock edge of the 112th such tick and not before.
- R6: If `over_flag` falls before qualification completes, the tick count is discarded. The next qualification then needs a fresh 112 ticks.
- R7: Once `gate_inhibit` is high, it stays high for exactly 3000 ticks and falls on the edge of the 3000th tick, whatever the estimate does meanwhile.
- R8: Ticks taken during the off interval do not count toward qualification. After a retry under persistent overload, the gate is inhibited again only after another full 112 ticks.
- R9: `hiccup_count` increases by one each time an off interval starts. It saturates at 15 (all ones, 4 bits) and changes at no other time.
- R10: While `over_flag` is low, ticks never raise `gate_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 1 ms timebase pulse |
| est_vld | input | 1 | Power estimate update strobe |
| est_pct | input | 8 | Output power estimate, percent of rated, unsigned |
| gate_inhibit | output | 1 | High during the off interval; forces the gate driver off |
| over_flag | output | 1 | Hysteresis comparator state: overload present |
| hiccup_count | output | 4 | Number of off intervals started, saturating |

## Verification
The hardest condition to reach from the ports is counter saturation. It takes fifteen complete qualify-and-off rounds, each of 3112 ticks. The stimulus holds the estimate at 200% and drives a tick on every cycle until the count pins at its top value. Another hard case is an overload that drops into the hysteresis band and then out of it just one tick short of tripping. The stimulus builds this by splitting the qualification window across table rows at 127% and 124%, and then leaving the band at 121%. An asynchronous reset applied during a live off interval checks that the shutdown state is dropped at once.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic {
    ST_RUN = 1'b0,
    ST_OFF = 1'b1
  } ovp_state_e;
endpackage

// File: rtl/ovp_rst_sync.sv
module ovp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/ovp_hyst_cmp.sv
module ovp_hyst_cmp #(
  parameter int PCT_W    = 8,
  parameter int TRIP_PCT = 127,
  parameter int HYST_PCT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [PCT_W-1:0] pct,
  output logic             over
);
  localparam logic [PCT_W-1:0] SetLvl = PCT_W'(TRIP_PCT);
  localparam logic [PCT_W-1:0] ClrLvl = PCT_W'(TRIP_PCT - HYST_PCT);

  logic over_q;
  logic over_d;

  always_comb begin
    over_d = over_q;
    if (pct >= SetLvl) begin
      over_d = 1'b1;
    end else if (pct < ClrLvl) begin
      over_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q <= 1'b0;
    end else if (upd) begin
      over_q <= over_d;
    end
  end

  assign over = over_q;
endmodule

// File: rtl/ovp_tick_timer.sv
module ovp_tick_timer #(
  parameter int LIMIT = 112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LastVal = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;
  logic         at_last;

  assign at_last = (cnt_q == LastVal);
  assign done    = step && at_last && !clr;
  assign cnt_ce  = clr || step;

  always_comb begin
    if (clr || at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ovp_hiccup_timer.sv
module ovp_hiccup_timer #(
  parameter int PCT_W      = 8,
  parameter int TRIP_PCT   = 127,
  parameter int HYST_PCT   = 5,
  parameter int QUAL_TICKS = 112,
  parameter int OFF_TICKS  = 3000,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             est_vld,
  input  logic [PCT_W-1:0] est_pct,
  output logic             gate_inhibit,
  output logic             over_flag,
  output logic [CNT_W-1:0] hiccup_count
);
  import ovp_pkg::*;

  localparam logic [CNT_W-1:0] CntMax = '1;

  logic       rst_sync_n;
  ovp_state_e state_q;
  ovp_state_e state_d;
  logic       over_w;
  logic       qual_done;
  logic       off_done;
  logic       qual_clr;
  logic       qual_step;
  logic       off_clr;
  logic       off_step;
  logic       enter_off;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  ovp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ovp_hyst_cmp #(
    .PCT_W    (PCT_W),
    .TRIP_PCT (TRIP_PCT),
    .HYST_PCT (HYST_PCT)
  ) u_cmp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .upd   (est_vld),
    .pct   (est_pct),
    .over  (over_w)
  );

  // qualification window: runs only in RUN while the comparator holds
  assign qual_clr  = (state_q != ST_RUN) || !over_w;
  assign qual_step = tick && over_w && (state_q == ST_RUN);

  ovp_tick_timer #(.LIMIT(QUAL_TICKS)) u_qual (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (qual_clr),
    .step  (qual_step),
    .done  (qual_done)
  );

  // off interval: runs only in OFF, independent of the estimate
  assign off_clr  = (state_q != ST_OFF);
  assign off_step = tick && (state_q == ST_OFF);

  ovp_tick_timer #(.LIMIT(OFF_TICKS)) u_off (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (off_clr),
    .step  (off_step),
    .done  (off_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (qual_done) state_d = ST_OFF;
      ST_OFF:  if (off_done)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign enter_off = (state_q == ST_RUN) && (state_d == ST_OFF);
  assign cnt_ce    = enter_off && (cnt_q != CntMax);
  assign cnt_d     = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign gate_inhibit = (state_q == ST_OFF);
  assign over_flag    = over_w;
  assign hiccup_count = cnt_q;
endmodule

// File: rtl/ovp_hiccup_timer_chk.sv
module ovp_hiccup_timer_chk #(
  parameter int PCT_W    = 8,
  parameter int TRIP_PCT = 127,
  parameter int HYST_PCT = 5,
  parameter int CNT_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             est_vld,
  input logic [PCT_W-1:0] est_pct,
  input logic             gate_inhibit,
  input logic             over_flag,
  input logic [CNT_W-1:0] hiccup_count
);
  localparam logic [PCT_W-1:0] SetLvl = PCT_W'(TRIP_PCT);
  localparam logic [PCT_W-1:0] ClrLvl = PCT_W'(TRIP_PCT - HYST_PCT);
  localparam logic [CNT_W-1:0] CntMax = '1;

  a_r2_set_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (est_vld && est_pct >= SetLvl) |=> over_flag);

  a_r3_clear_below_band: assert property (@(posedge clk) disable iff (!rst_n)
    (est_vld && est_pct < ClrLvl) |=> !over_flag);

  a_r3_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (est_vld && est_pct < SetLvl && est_pct >= ClrLvl) |=> $stable(over_flag));

  a_r4_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !est_vld |=> $stable(over_flag));

  a_r5_trip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_inhibit) |-> ($past(tick) && $past(over_flag)));

  a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_inhibit) |-> $past(tick));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_inhibit) && $past(hiccup_count) != CntMax)
      |-> (hiccup_count == CNT_W'($past(hiccup_count) + CNT_W'(1))));

  a_r9_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(gate_inhibit) |-> $stable(hiccup_count));

  a_r10_no_trip_without_over: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_inhibit && !over_flag) |=> !gate_inhibit);
endmodule

bind ovp_hiccup_timer ovp_hiccup_timer_chk #(
  .PCT_W    (PCT_W),
  .TRIP_PCT (TRIP_PCT),
  .HYST_PCT (HYST_PCT),
  .CNT_W    (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick         (tick),
  .est_vld      (est_vld),
  .est_pct      (est_pct),
  .gate_inhibit (gate_inhibit),
  .over_flag    (over_flag),
  .hiccup_count (hiccup_count)
);

// File: tb/ovp_hiccup_timer_tb.sv
`timescale 1ns/1ps
module ovp_hiccup_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       est_vld;
  logic [7:0] est_pct;
  logic       gate_inhibit;
  logic       over_flag;
  logic [3:0] hiccup_count;

  int checks;
  int errors;
  bit done_flag;

  ovp_hiccup_timer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .est_vld      (est_vld),
    .est_pct      (est_pct),
    .gate_inhibit (gate_inhibit),
    .over_flag    (over_flag),
    .hiccup_count (hiccup_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // row: pct[26:19] vld[18] ticks[17:6] over[5] gate[4] cnt[3:0]
  localparam int NROWS = 12;
  localparam logic [26:0] VEC [NROWS] = '{
    {8'd100, 1'b1, 12'd5,    1'b0, 1'b0, 4'd0}, // R10 low estimate, ticks ignored
    {8'd130, 1'b0, 12'd5,    1'b0, 1'b0, 4'd0}, // R4 no strobe
    {8'd127, 1'b1, 12'd50,   1'b1, 1'b0, 4'd0}, // R2 set at trip level
    {8'd124, 1'b1, 12'd61,   1'b1, 1'b0, 4'd0}, // R3 hold in band, 111 ticks
    {8'd121, 1'b1, 12'd0,    1'b0, 1'b0, 4'd0}, // R6 drop out clears window
    {8'd200, 1'b1, 12'd111,  1'b1, 1'b0, 4'd0}, // R6/R5 fresh window, one short
    {8'd200, 1'b1, 12'd1,    1'b1, 1'b1, 4'd1}, // R5 112th tick trips
    {8'd200, 1'b1, 12'd2999, 1'b1, 1'b1, 4'd1}, // R7 still off
    {8'd200, 1'b1, 12'd1,    1'b1, 1'b0, 4'd1}, // R7 released at 3000
    {8'd255, 1'b1, 12'd111,  1'b1, 1'b0, 4'd1}, // R8 full window again
    {8'd255, 1'b1, 12'd1,    1'b1, 1'b1, 4'd2}, // R8 second trip
    {8'd0,   1'b1, 12'd3000, 1'b0, 1'b0, 4'd2}  // R7 off runs out though load gone
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_est(input logic [7:0] pct, input logic vld);
    @(negedge clk);
    est_pct = pct;
    est_vld = vld;
    @(negedge clk);
    est_vld = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done_flag = 1'b0;
    rst_n = 1'b0;
    tick = 1'b0;
    est_vld = 1'b0;
    est_pct = '0;
    repeat (3) @(negedge clk);
    chk("R1 gate at reset", int'(gate_inhibit), 0);
    chk("R1 over at reset", int'(over_flag), 0);
    chk("R1 count at reset", int'(hiccup_count), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      apply_est(VEC[i][26:19], VEC[i][18]);
      run_ticks(int'(VEC[i][17:6]));
      chk($sformatf("row %0d over_flag", i), int'(over_flag), int'(VEC[i][5]));
      chk($sformatf("row %0d gate_inhibit", i), int'(gate_inhibit), int'(VEC[i][4]));
      chk($sformatf("row %0d hiccup_count", i), int'(hiccup_count), int'(VEC[i][3:0]));
    end

    // R9 saturation under persistent overload
    apply_est(8'd200, 1'b1);
    for (int k = 3; k <= 16; k++) begin
      run_ticks(111);
      chk("R8 no trip before window", int'(gate_inhibit), 0);
      run_ticks(1);
      chk("R5 trip", int'(gate_inhibit), 1);
      chk("R9 count", int'(hiccup_count), (k > 15) ? 15 : k);
      run_ticks(3000);
      chk("R7 retry", int'(gate_inhibit), 0);
    end
    chk("R9 saturated", int'(hiccup_count), 15);

    // R1 reset in the middle of an off interval
    run_ticks(112);
    chk("R1 pre-reset gate", int'(gate_inhibit), 1);
    run_ticks(40);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async gate", int'(gate_inhibit), 0);
    chk("R1 async count", int'(hiccup_count), 0);
    chk("R1 async over", int'(over_flag), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_ticks(200);
    chk("R10 no trip after reset", int'(gate_inhibit), 0);

    done_flag = 1'b1;
    finish_up();
  end
endmodule